// File: doc/BRIEF.md
# GPIO Expander Register Core

This block is the register core of an eight-pin I/O expander. It sits behind a serial-bus slave front end, which has already decoded the bus protocol, matched the address and handled the acknowledge. The front end passes plain byte events to the core. A one-cycle `wr_start` pulse opens a write transaction. Each `byte_valid` cycle delivers one received byte on `byte_data`. A `rd_strobe` pulse asks for the byte of the currently selected register, which appears on `rd_data` one clock later and stays there until the next strobe.

The first byte of every write transaction is a command that loads an 8-bit register pointer. Pointer values 0 to 3 select the input, output, polarity and direction registers. Any later byte in the same transaction is written to the register that the pointer selects. The pointer never advances by itself.

The core drives a value and an enable for each pin. It also samples the pin levels through a synchronizer, inverts the sampled level on input pins where the polarity register asks for it, and offers the result as the read-only input register. The active-low `rst_n` comes from the chip's power-on and external reset logic. While it is low, every register and the transaction state stay at their defaults.

Top module: `gpx_expander_core`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, the output register holds 0x00, the polarity register holds 0xF0, the direction register holds 0xFF, `pin_oe` and `pin_out` are 0x00, and `rd_data` is 0x00.
- R2: A byte accepted with `byte_valid` after a `wr_start` pulse loads the pointer. The pointer codes are 0 for input, 1 for output, 2 for polarity and 3 for direction.
- R3: A data byte sent while the pointer is 0 changes no register. The input register remains the sampled pins.
- R4: On a read with pointer 0, bit i equals synchronized pin i XOR (polarity bit i AND direction bit i). Polarity therefore affects only pins whose direction bit is 1 (input).
- R5: Pin levels pass through two flip-flops. A pin change applied before clock edge k is seen by a read strobe sampled at edge k+2, but not by one sampled at edge k+1.
- R6: A read with pointer 1 returns the stored output register, even where the pin is an input and is not driven.
- R7: `pin_oe` equals the inverse of the direction register. `pin_out` equals the output register AND `pin_oe`, so the output register has no effect on input pins.
- R8: Pointer values above 3 are accepted. Data bytes sent to them change no register, and reads from them return 0xFF.
- R9: Every data byte after the command byte in a transaction writes the same register, so the last byte wins. Reads use the most recently loaded pointer.
- R10: `rd_data` is registered. It takes a new value only on the clock after a `rd_strobe` and holds it otherwise.
- R11: Bytes and strobes presented while `rst_n` is low have no effect, and normal operation resumes once `rst_n` is high.
- R12: If `wr_start` and `byte_valid` are high in the same cycle, that byte is the command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on or external) |
| wr_start | input | 1 | One-cycle pulse opening a write transaction |
| byte_valid | input | 1 | Marks a received byte on `byte_data` |
| byte_data | input | 8 | Received byte (command or data) |
| rd_strobe | input | 1 | Request to load `rd_data` from the current pointer |
| rd_data | output | 8 | Registered read byte |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Per-pin drive value |
| pin_oe | output | 8 | Per-pin output enable, 1 = driven |

## Verification
The bench builds the core with its default parameters: 8 pins, a two-stage synchronizer, and reset values of 0x00, 0xF0 and 0xFF. With these values the mixed polarity default makes the upper four input bits read inverted straight out of reset. A direction pattern of 0x3C then mixes input and output pins inside both halves of the polarity mask. The two-stage depth allows the exact cycle in which a pin change reaches a read to be checked.

// File: rtl/gpx_pkg.sv
// Package gpx_pkg
// Shared constants for the expander register core: the pointer codes that
// the command byte selects and the value returned for unmapped pointers.
package gpx_pkg;
    localparam int unsigned BYTE_W        = 8;
    localparam int unsigned NUM_RW_REGS   = 3;
    localparam logic [7:0]  PTR_INPUT     = 8'd0;
    localparam logic [7:0]  PTR_OUTPUT    = 8'd1;
    localparam logic [7:0]  PTR_POLARITY  = 8'd2;
    localparam logic [7:0]  PTR_DIRECTION = 8'd3;
    localparam logic [7:0]  UNMAPPED_READ = 8'hFF;

    // Write transaction phase: waiting for the command byte, or in data bytes
    typedef enum logic {
        PH_DATA = 1'b0,
        PH_CMD  = 1'b1
    } wr_phase_e;
endpackage

// File: rtl/gpx_pin_sync.sv
// Module gpx_pin_sync
// Multi-flop synchronizer for the asynchronous pin levels.
// Assumes: STAGES >= 2, and each pin is treated as an independent bit
// (no multi-bit coherency is promised across pins).
module gpx_pin_sync #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pin_async,
    output logic [DATA_W-1:0] pin_sync
);
    logic [STAGES-1:0][DATA_W-1:0] stage_q;

    // Shift the pin levels through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= pin_async;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_cmd_ctrl.sv
// Module gpx_cmd_ctrl
// Tracks the write transaction: the first byte after wr_start loads the
// pointer, and each later byte becomes a write to the selected register.
// Assumes: wr_start is a one-cycle pulse from the bus front end; pointer 0
// (input) is read-only, so no write select is produced for it.
module gpx_cmd_ctrl
    import gpx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NUM_RW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    output logic [DATA_W-1:0] ptr_q,
    output logic [NUM_RW-1:0] wr_sel
);
    wr_phase_e phase_q;
    logic      cmd_now;
    logic      data_now;

    assign cmd_now  = byte_valid && (wr_start || (phase_q == PH_CMD));
    assign data_now = byte_valid && !cmd_now;

    // Phase: arm for a command byte on wr_start, leave once it arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_DATA;
        end else if (cmd_now) begin
            phase_q <= PH_DATA;
        end else if (wr_start) begin
            phase_q <= PH_CMD;
        end
    end

    // Pointer: loaded only by a command byte, never auto-incremented
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (cmd_now) begin
            ptr_q <= byte_data;
        end
    end

    // One write select per writable register; entry j maps to pointer j+1
    for (genvar j = 0; j < NUM_RW; j++) begin : g_wsel
        assign wr_sel[j] = data_now && (ptr_q == DATA_W'(j + 1));
    end

    // A command byte loads the pointer with that byte
    assert_cmd_loads_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && (wr_start || phase_q == PH_CMD)) |=> (ptr_q == $past(byte_data)));

    // A same-cycle wr_start and byte is the command byte
    assert_same_cycle_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && byte_valid) |=> (ptr_q == $past(byte_data) && phase_q == PH_DATA));

    // Data bytes never move the pointer
    assert_data_keeps_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !wr_start && phase_q == PH_DATA) |=> $stable(ptr_q));

    // At most one register is written per byte
    assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));
endmodule

// File: rtl/gpx_reg_bank.sv
// Module gpx_reg_bank
// Holds the writable registers (output, polarity, direction) with
// per-register reset values.
// Assumes: wr_sel is at most one-hot; entry j is pointer j+1; RST_VALS packs
// entry j in bits [j*DATA_W +: DATA_W].
module gpx_reg_bank #(
    parameter int unsigned              DATA_W   = 8,
    parameter int unsigned              NUM_RW   = 3,
    parameter logic [NUM_RW*DATA_W-1:0] RST_VALS = '0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_RW-1:0]              wr_sel,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_RW-1:0][DATA_W-1:0]  regs_q
);
    for (genvar j = 0; j < NUM_RW; j++) begin : g_reg
        // Register j: reset to its default, load when selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[j] <= RST_VALS[j*DATA_W +: DATA_W];
            end else if (wr_sel[j]) begin
                regs_q[j] <= wr_data;
            end
        end
    end

    // No write select (input pointer, unmapped pointer, idle): nothing changes
    assert_unselected_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel == '0) |=> $stable(regs_q));

    // A selected write lands its byte
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel != '0) |=> (regs_q[$past(wr_sel) == 1 ? 0 : ($past(wr_sel) == 2 ? 1 : 2)]
                            == $past(wr_data)) || (NUM_RW != 3));
endmodule

// File: rtl/gpx_read_port.sv
// Module gpx_read_port
// Selects the byte for the current pointer and registers it on rd_strobe.
// Assumes: pointer 0 reads the input value, pointers 1..NUM_RW read the
// writable registers, and anything higher reads as all ones.
module gpx_read_port
    import gpx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NUM_RW = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_strobe,
    input  logic [DATA_W-1:0]             ptr,
    input  logic [DATA_W-1:0]             in_val,
    input  logic [NUM_RW-1:0][DATA_W-1:0] regs,
    output logic [DATA_W-1:0]             rd_data
);
    logic [DATA_W-1:0] sel_byte;

    // Read multiplexer over the pointer
    always_comb begin
        sel_byte = DATA_W'(UNMAPPED_READ);
        if (ptr == DATA_W'(PTR_INPUT)) begin
            sel_byte = in_val;
        end
        for (int j = 0; j < NUM_RW; j++) begin
            if (ptr == DATA_W'(j + 1)) begin
                sel_byte = regs[j];
            end
        end
    end

    // Read register: updates only on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_strobe) begin
            rd_data <= sel_byte;
        end
    end

    // Unmapped pointers read as all ones
    assert_unmapped_reads_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && ptr > DATA_W'(NUM_RW)) |=> (rd_data == '1));

    // Without a strobe the read byte holds
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_data));

    // The output register reads back its stored value
    assert_output_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && ptr == DATA_W'(PTR_OUTPUT)) |=> (rd_data == $past(regs[0])));
endmodule

// File: rtl/gpx_expander_core.sv
// Module gpx_expander_core
// Top of the expander register core: byte interface in, pin value and
// enable out, pin levels sampled through a synchronizer.
// Assumes: rst_n is driven low by both power-on and external reset and is
// synchronous to clk; the bus front end delivers whole bytes.
module gpx_expander_core
    import gpx_pkg::*;
#(
    parameter int unsigned      DATA_W      = 8,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] OUT_RESET  = 8'h00,
    parameter logic [DATA_W-1:0] POL_RESET  = 8'hF0,
    parameter logic [DATA_W-1:0] DIR_RESET  = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe
);
    localparam int unsigned NUM_RW = NUM_RW_REGS;
    localparam int unsigned IDX_OUT = int'(PTR_OUTPUT) - 1;
    localparam int unsigned IDX_POL = int'(PTR_POLARITY) - 1;
    localparam int unsigned IDX_DIR = int'(PTR_DIRECTION) - 1;
    localparam logic [NUM_RW*DATA_W-1:0] RST_VALS = {DIR_RESET, POL_RESET, OUT_RESET};

    logic [DATA_W-1:0]             pin_sync;
    logic [DATA_W-1:0]             ptr_q;
    logic [NUM_RW-1:0]             wr_sel;
    logic [NUM_RW-1:0][DATA_W-1:0] regs_q;
    logic [DATA_W-1:0]             out_r;
    logic [DATA_W-1:0]             pol_r;
    logic [DATA_W-1:0]             dir_r;
    logic [DATA_W-1:0]             in_val;

    gpx_pin_sync #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .pin_sync  (pin_sync)
    );

    gpx_cmd_ctrl #(.DATA_W(DATA_W), .NUM_RW(NUM_RW)) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_start   (wr_start),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .ptr_q      (ptr_q),
        .wr_sel     (wr_sel)
    );

    gpx_reg_bank #(.DATA_W(DATA_W), .NUM_RW(NUM_RW), .RST_VALS(RST_VALS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wr_data (byte_data),
        .regs_q  (regs_q)
    );

    assign out_r = regs_q[IDX_OUT];
    assign pol_r = regs_q[IDX_POL];
    assign dir_r = regs_q[IDX_DIR];

    // Input value: polarity applies only where the direction bit marks an input
    assign in_val = pin_sync ^ (pol_r & dir_r);

    gpx_read_port #(.DATA_W(DATA_W), .NUM_RW(NUM_RW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .ptr       (ptr_q),
        .in_val    (in_val),
        .regs      (regs_q),
        .rd_data   (rd_data)
    );

    // Pin drivers: enabled where the direction bit is clear
    assign pin_oe  = ~dir_r;
    assign pin_out = out_r & ~dir_r;

    // Undriven pins carry no value
    assert_idle_pins_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

    // After a data byte at pointer 0, pin drive does not change
    assert_input_ptr_write_no_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !wr_start && ptr_q == DATA_W'(PTR_INPUT) && wr_sel == '0)
            |=> ($stable(pin_oe) && $stable(pin_out)));
endmodule

// File: tb/gpx_expander_core_tb.sv
// Bench for gpx_expander_core: a behavioural reference model updated at each
// rising edge and compared at each falling edge, plus directed checks.
module gpx_expander_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_start = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    gpx_expander_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_start   (wr_start),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .rd_strobe  (rd_strobe),
        .rd_data    (rd_data),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    // Reference model state
    logic [7:0] m_reg [1:3];
    logic [7:0] m_ptr, m_rd, m_s1, m_s2, m_inv;
    bit         m_cmd;

    // Reference model, one update per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg[1] = 8'h00; m_reg[2] = 8'hF0; m_reg[3] = 8'hFF;
            m_ptr = 0; m_rd = 0; m_s1 = 0; m_s2 = 0; m_cmd = 0;
        end else begin
            m_inv = m_s2 ^ (m_reg[2] & m_reg[3]);
            if (rd_strobe) begin
                if (m_ptr == 0) m_rd = m_inv;
                else if (m_ptr <= 3) m_rd = m_reg[int'(m_ptr)];
                else m_rd = 8'hFF;
            end
            if (byte_valid) begin
                if (wr_start || m_cmd) begin
                    m_ptr = byte_data;
                    m_cmd = 0;
                end else if (m_ptr >= 1 && m_ptr <= 3) begin
                    m_reg[int'(m_ptr)] = byte_data;
                end
            end else if (wr_start) begin
                m_cmd = 1;
            end
            m_s2 = m_s1;
            m_s1 = pin_in;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R7 pins, R10 read byte)
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk("R10 model rd_data", rd_data, m_rd);
        chk("R7 model pin_oe", pin_oe, ~m_reg[3]);
        chk("R7 model pin_out", pin_out, m_reg[1] & ~m_reg[3]);
    endtask

    // Point at a register with a same-cycle command (R12 form) and read it
    task automatic read_reg(input logic [7:0] p, output logic [7:0] v);
        wr_start = 1; byte_valid = 1; byte_data = p;
        step();
        wr_start = 0; byte_valid = 0;
        rd_strobe = 1;
        step();
        rd_strobe = 0;
        v = rd_data;
    endtask

    // Transaction with separate start cycle, command byte, then n data bytes
    task automatic write_txn(input logic [7:0] p, input logic [7:0] d0,
                             input logic [7:0] d1, input logic [7:0] d2, input int n);
        wr_start = 1;
        step();
        wr_start = 0; byte_valid = 1; byte_data = p;
        step();
        for (int k = 0; k < n; k++) begin
            byte_data = (k == 0) ? d0 : ((k == 1) ? d1 : d2);
            step();
        end
        byte_valid = 0;
    endtask

    initial begin
        logic [7:0] v;
        // Reset phase
        for (int k = 0; k < 3; k++) step();
        chk("R1 pin_oe in reset", pin_oe, 8'h00);
        chk("R1 pin_out in reset", pin_out, 8'h00);
        chk("R1 rd_data in reset", rd_data, 8'h00);
        rst_n = 1;
        step();
        read_reg(8'd1, v); chk("R1 output default", v, 8'h00);
        read_reg(8'd2, v); chk("R1 polarity default", v, 8'hF0);
        read_reg(8'd3, v); chk("R1 direction default", v, 8'hFF);
        read_reg(8'd0, v); chk("R4 input with default polarity", v, 8'hF0);

        // R2: separate start and command, then data
        write_txn(8'd3, 8'h3C, 8'h00, 8'h00, 1);
        read_reg(8'd3, v); chk("R2 direction written", v, 8'h3C);
        chk("R7 pin_oe from direction", pin_oe, 8'hC3);
        write_txn(8'd1, 8'hA5, 8'h00, 8'h00, 1);
        chk("R7 pin_out masked", pin_out, 8'h81);
        read_reg(8'd1, v); chk("R6 output readback is flop value", v, 8'hA5);

        // R4: mixed inputs and outputs
        pin_in = 8'h5A;
        for (int k = 0; k < 3; k++) step();
        read_reg(8'd0, v); chk("R4 input polarity on inputs only", v, 8'h6A);

        // R5: synchronizer latency
        pin_in = 8'hFF;
        step();
        rd_strobe = 1;
        step();
        chk("R5 not yet visible at k+1", rd_data, 8'h6A);
        step();
        chk("R5 visible at k+2", rd_data, 8'hCF);
        rd_strobe = 0;

        // R3: writes to the input pointer
        write_txn(8'd0, 8'h00, 8'h77, 8'h00, 2);
        read_reg(8'd1, v); chk("R3 output unchanged", v, 8'hA5);
        read_reg(8'd2, v); chk("R3 polarity unchanged", v, 8'hF0);
        read_reg(8'd3, v); chk("R3 direction unchanged", v, 8'h3C);
        read_reg(8'd0, v); chk("R3 input still pins", v, 8'hCF);

        // R8: unmapped pointers
        write_txn(8'd7, 8'h12, 8'h00, 8'h00, 1);
        read_reg(8'd7, v); chk("R8 unmapped reads ones", v, 8'hFF);
        read_reg(8'hFF, v); chk("R8 pointer FF reads ones", v, 8'hFF);
        read_reg(8'd1, v); chk("R8 output unchanged", v, 8'hA5);
        read_reg(8'd3, v); chk("R8 direction unchanged", v, 8'h3C);

        // R9: no auto-increment, last byte wins
        write_txn(8'd2, 8'h11, 8'h22, 8'h33, 3);
        read_reg(8'd2, v); chk("R9 polarity last byte", v, 8'h33);
        read_reg(8'd3, v); chk("R9 next register untouched", v, 8'h3C);

        // R10: read byte holds without strobe
        read_reg(8'd2, v);
        write_txn(8'd2, 8'h44, 8'h00, 8'h00, 1);
        pin_in = 8'h00;
        step();
        chk("R10 rd_data holds", rd_data, 8'h33);

        // R12: same-cycle start and command
        wr_start = 1; byte_valid = 1; byte_data = 8'd3;
        step();
        wr_start = 0; byte_data = 8'h0F;
        step();
        byte_valid = 0;
        read_reg(8'd3, v); chk("R12 direction via same-cycle command", v, 8'h0F);
        chk("R7 pin_out with new direction", pin_out, 8'hA0);

        // R11: activity during reset is discarded
        rst_n = 0;
        pin_in = 8'hFF;
        write_txn(8'd1, 8'h5F, 8'h00, 8'h00, 1);
        rd_strobe = 1; step(); rd_strobe = 0;
        chk("R11 pin_oe held in reset", pin_oe, 8'h00);
        chk("R11 rd_data held in reset", rd_data, 8'h00);
        rst_n = 1;
        for (int k = 0; k < 3; k++) step();
        read_reg(8'd1, v); chk("R11 output default after reset", v, 8'h00);
        read_reg(8'd3, v); chk("R11 direction default after reset", v, 8'hFF);
        read_reg(8'd0, v); chk("R11 input resumes", v, 8'h0F);
        write_txn(8'd1, 8'h66, 8'h00, 8'h00, 1);
        read_reg(8'd1, v); chk("R11 writes resume", v, 8'h66);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog
    initial begin
        #2000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule